// File: doc/BRIEF.md
# Slope-Triggered R-Peak Detector

This block watches a stream of signed ECG samples and reports where the R waves of the heartbeat fall. Each sample arrives through a valid/ready handshake. The block subtracts the previous sample from it and compares the size of that step with a threshold held on a configuration input. The threshold is worked out offline and stays fixed while the block runs. A step larger than the threshold opens a search window. Inside that window one signed comparator, reused once per sample, keeps track of the highest raw value and where it occurred.

When the window closes, the block spends one decision cycle judging the peak it found. The peak must not come too soon after the previous accepted beat, measured against a running estimate of the beat-to-beat (RR) interval. An accepted peak produces a one-cycle strobe that carries its sample index. The RR estimate is then moved toward the new interval. A fault flag rises when the stream goes on too long without a beat.

Top module: `rpeak_detector`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block resets synchronously. After reset, `peak_valid` and `fault` are 0, `s_ready` is 1, and `rr_est` equals `rr_default`.
- R2: When no search is open, an accepted sample opens a search if `|x[n] - x[n-1]|` is strictly greater than `thresh`. The previous sample counts as 0 after reset. A step exactly equal to `thresh` opens nothing.
- R3: A search window is the sample that opened it plus the next WIN-1 accepted samples (WIN = 16). Its result is the index of the largest raw sample in the window, taking the earliest one if several are equal. Samples inside an open window never open a new one.
- R4: `peak_index` is the zero-based count of samples accepted since reset, so the first accepted sample has index 0. Reported indices strictly increase.
- R5: The first peak after reset is always accepted, and it leaves `rr_est` unchanged.
- R6: A later peak whose distance from the last accepted peak is less than `rr_est >> 1` is discarded. A discarded peak gives no strobe and changes neither `rr_est` nor the reference point used for later distances.
- R7: Each accepted peak after the first sets `rr_est` to `rr_est - (rr_est >> 3) + (interval >> 3)`, where interval is its distance from the previous accepted peak. `rr_est` changes at no other time.
- R8: `peak_valid` is high for exactly one cycle. It rises at the second clock edge after the handshake of the window's last sample.
- R9: `s_ready` is low for exactly one cycle per closed window: the decision cycle that follows the handshake of the window's last sample. It is high at all other times.
- R10: `fault` is set when a sample is accepted whose index exceeds the last accepted peak index by more than `2*rr_est`. It is cleared by the next accepted peak, and it stays 0 before the first peak.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| s_valid | input | 1 | Sample present |
| s_ready | output | 1 | Block can take a sample |
| s_data | input | DW (12) | Signed ECG sample |
| thresh | input | DW+1 | Step-size threshold, unsigned |
| rr_default | input | RW (16) | RR estimate loaded at reset |
| peak_valid | output | 1 | One-cycle strobe for an accepted peak |
| peak_index | output | IW (32) | Sample index of the accepted peak |
| rr_est | output | RW (16) | Running RR-interval estimate in samples |
| fault | output | 1 | No beat within twice the RR estimate |

## Verification
The bench sweeps beat period, threshold and starting RR estimate over synthetic beat trains. The trains carry small positive blips that fall inside the refractory zone and negative dips whose windows run into the next beat. A design that let a blip through, or did not hold the refractory reference still across a rejected peak, would report extra or shifted indices and drift `rr_est`. Separate streams test a step exactly equal to the threshold and two equal maxima in one window; a non-strict compare would open a spurious window or report the later peak. The fault flag is compared after every sample, so a boundary that is off by one, or a flag that fires before the first beat, is caught at the exact sample where it goes wrong.

// File: rtl/rpeak_detector.sv
module rpeak_detector #(
  parameter int DW  = 12,
  parameter int IW  = 32,
  parameter int RW  = 16,
  parameter int WIN = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic signed [DW-1:0] s_data,
  input  logic [DW:0]          thresh,
  input  logic [RW-1:0]        rr_default,
  output logic                 peak_valid,
  output logic [IW-1:0]        peak_index,
  output logic [RW-1:0]        rr_est,
  output logic                 fault
);
  localparam int CW = $clog2(WIN + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SEARCH, ST_DECIDE} st_t;
  st_t st;

  logic signed [DW-1:0] prev, best;
  logic [IW-1:0]        idx, best_idx, last_idx;
  logic [CW-1:0]        cnt;
  logic                 have;

  wire take = s_valid && s_ready;
  assign s_ready = (st != ST_DECIDE);

  wire signed [DW:0] step = {s_data[DW-1], s_data} - {prev[DW-1], prev};
  wire [DW:0]        mag  = step[DW] ? (~step + 1'b1) : step;
  wire               cand = take && (st == ST_IDLE) && (mag > thresh);
  wire               bigger = s_data > best;

  wire [IW-1:0] rr_ext  = {{(IW-RW){1'b0}}, rr_est};
  wire [IW-1:0] ivl     = best_idx - last_idx;
  wire [RW-1:0] ivl_sat = (|ivl[IW-1:RW]) ? {RW{1'b1}} : ivl[RW-1:0];
  wire          accept  = !have || (ivl >= (rr_ext >> 1));
  wire          late    = have && ((idx - last_idx) > (rr_ext << 1));
  wire [RW-1:0] rr_next = rr_est - (rr_est >> 3) + (ivl_sat >> 3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      prev       <= '0;
      best       <= '0;
      idx        <= '0;
      best_idx   <= '0;
      last_idx   <= '0;
      cnt        <= '0;
      have       <= 1'b0;
      rr_est     <= rr_default;
      peak_valid <= 1'b0;
      peak_index <= '0;
      fault      <= 1'b0;
    end else begin
      peak_valid <= 1'b0;
      if (take) begin
        prev <= s_data;
        idx  <= idx + 1'b1;
        if (late) fault <= 1'b1;
      end
      case (st)
        ST_IDLE: if (cand) begin
          best     <= s_data;
          best_idx <= idx;
          cnt      <= CW'(1);
          st       <= (WIN == 1) ? ST_DECIDE : ST_SEARCH;
        end
        ST_SEARCH: if (take) begin
          if (bigger) begin
            best     <= s_data;
            best_idx <= idx;
          end
          cnt <= cnt + 1'b1;
          if (cnt == CW'(WIN - 1)) st <= ST_DECIDE;
        end
        ST_DECIDE: begin
          st <= ST_IDLE;
          if (accept) begin
            peak_valid <= 1'b1;
            peak_index <= best_idx;
            last_idx   <= best_idx;
            have       <= 1'b1;
            fault      <= 1'b0;
            if (have) rr_est <= rr_next;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

module rpeak_detector_chk #(
  parameter int IW = 32,
  parameter int RW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_ready,
  input logic          peak_valid,
  input logic [IW-1:0] peak_index,
  input logic [RW-1:0] rr_est,
  input logic          fault
);
  logic          seen;
  logic [IW-1:0] last_pk;
  logic [RW-1:0] rr_at;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen    <= 1'b0;
      last_pk <= '0;
      rr_at   <= '0;
    end else if (peak_valid) begin
      seen    <= 1'b1;
      last_pk <= peak_index;
      rr_at   <= rr_est;
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) peak_valid |=> !peak_valid); // R8
  AST_PULSE_AFTER_STALL: assert property (@(posedge clk) disable iff (!rst_n) peak_valid |-> $past(!s_ready)); // R8
  AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) !s_ready |=> s_ready); // R9
  AST_INDEX_RISE: assert property (@(posedge clk) disable iff (!rst_n) (peak_valid && seen) |-> (peak_index > last_pk)); // R4
  AST_REFRACTORY: assert property (@(posedge clk) disable iff (!rst_n)
    (peak_valid && seen) |-> ((peak_index - last_pk) >= {{(IW-RW){1'b0}}, rr_at >> 1})); // R6
  AST_RR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !$stable(rr_est) |-> peak_valid); // R7
  AST_FIRST_KEEPS_RR: assert property (@(posedge clk) disable iff (!rst_n) (peak_valid && !seen) |-> $stable(rr_est)); // R5
  AST_FAULT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n) peak_valid |-> !fault); // R10
  AST_NO_FAULT_EARLY: assert property (@(posedge clk) disable iff (!rst_n) !seen |-> !fault); // R10
endmodule

bind rpeak_detector rpeak_detector_chk #(.IW(IW), .RW(RW)) u_chk (.*);

// File: tb/test_rpeak_detector.sv
module test_rpeak_detector;
  localparam int DW = 12, IW = 32, RW = 16, WIN = 16;
  localparam int MAXS = 2048, MAXP = 256;

  logic clk = 1'b0, rst_n = 1'b0, s_valid = 1'b0;
  logic signed [DW-1:0] s_data = '0;
  logic [DW:0] thresh = '0;
  logic [RW-1:0] rr_default = '0;
  logic s_ready, peak_valid, fault;
  logic [IW-1:0] peak_index;
  logic [RW-1:0] rr_est;

  always #5 clk = ~clk;

  rpeak_detector #(.DW(DW), .IW(IW), .RW(RW), .WIN(WIN)) i_rpeak_detector (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .thresh(thresh), .rr_default(rr_default), .peak_valid(peak_valid),
    .peak_index(peak_index), .rr_est(rr_est), .fault(fault));

  int nchk = 0, nfail = 0;
  int samp [MAXS];
  int nsamp;
  int e_idx [MAXP], e_rr [MAXP];
  int e_np, e_win, e_rr_end;
  bit e_flt [MAXS];
  bit e_flt_end;
  int g_idx [MAXP], g_rr [MAXP];
  int g_np = 0, g_stall = 0;
  bit prev_pv = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (peak_valid) begin
        if (g_np < MAXP) begin
          g_idx[g_np] = int'(peak_index);
          g_rr[g_np]  = int'(rr_est);
        end
        g_np++;
      end
      if (peak_valid && prev_pv) chk(1'b0, "R8 strobe longer than one cycle", 2, 1);
      if (!s_ready) g_stall++;
      prev_pv = peak_valid;
    end else prev_pv = 1'b0;
  end

  // Reference built from the requirements
  task automatic model(input int th, input int rrd);
    int prv = 0, st = 0, best = 0, bi = 0, cnt = 0, last = 0, rr = rrd;
    bit have = 0, flt = 0;
    e_np = 0; e_win = 0;
    for (int i = 0; i < nsamp; i++) begin
      int x = samp[i];
      int d = x - prv;
      if (have && (i - last) > 2 * rr) flt = 1;      // R10
      e_flt[i] = flt;
      if (st == 0) begin
        if ((d < 0 ? -d : d) > th) begin st = 1; best = x; bi = i; cnt = 1; end  // R2
      end else begin
        if (x > best) begin best = x; bi = i; end    // R3
        cnt++;
      end
      prv = x;
      if (st == 1 && cnt == WIN) begin
        int ivl = bi - last;
        e_win++; st = 0;                             // R9
        if (!have || ivl >= rr / 2) begin            // R5 R6
          if (have) rr = rr - rr / 8 + (ivl > 65535 ? 65535 : ivl) / 8;  // R7
          e_idx[e_np] = bi; e_rr[e_np] = rr; e_np++;
          last = bi; have = 1; flt = 0;
        end
      end
    end
    e_rr_end = rr; e_flt_end = flt;
  endtask

  task automatic send(input int i);
    @(negedge clk);
    s_valid = 1'b1;
    s_data  = DW'(samp[i]);
    while (!s_ready) @(negedge clk);
    @(posedge clk);
    #2;
    chk(fault == e_flt[i], "R10 fault after sample", fault, e_flt[i]);
  endtask

  task automatic run(input int th, input int rrd, input string tag);
    model(th, rrd);
    @(negedge clk);
    rst_n = 1'b0; s_valid = 1'b0; thresh = (DW+1)'(th); rr_default = RW'(rrd);
    repeat (3) @(negedge clk);
    chk(!peak_valid && !fault && s_ready, "R1 outputs after reset", {peak_valid, fault, s_ready}, 1);
    chk(rr_est == RW'(rrd), "R1 rr_est after reset", rr_est, rrd);
    rst_n = 1'b1;
    g_np = 0; g_stall = 0;
    for (int i = 0; i < nsamp; i++) send(i);
    @(negedge clk);
    s_valid = 1'b0;
    repeat (6) @(negedge clk);
    chk(g_np == e_np, {"R3 R6 peak count ", tag}, g_np, e_np);
    for (int k = 0; k < e_np && k < g_np && k < MAXP; k++) begin
      chk(g_idx[k] == e_idx[k], {"R3 R4 peak index ", tag}, g_idx[k], e_idx[k]);
      chk(g_rr[k] == e_rr[k], {"R5 R7 rr_est at peak ", tag}, g_rr[k], e_rr[k]);
    end
    chk(g_stall == e_win, {"R9 stall cycles ", tag}, g_stall, e_win);
    chk(int'(rr_est) == e_rr_end, {"R7 final rr_est ", tag}, rr_est, e_rr_end);
    chk(fault == e_flt_end, {"R10 final fault ", tag}, fault, e_flt_end);
  endtask

  task automatic build_beats(input int p, input int nb, input int tail);
    for (int i = 0; i < MAXS; i++) samp[i] = 0;
    for (int b = 0; b < nb; b++) begin
      int t = 5 + b * p;
      samp[t] = 100; samp[t+1] = 400; samp[t+2] = 900; samp[t+3] = 600; samp[t+4] = 200;
      samp[t+18] = 150;
      if (t + p - 6 > t + 34) samp[t+p-6] = -300;
    end
    nsamp = 5 + nb * p + tail;
  endtask

  initial begin
    #(10 * 190000);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int periods [4] = '{40, 56, 80, 120};
    int ths [4] = '{99, 100, 250, 1000};
    // R2: a step equal to the threshold opens nothing, one above does
    for (int i = 0; i < MAXS; i++) samp[i] = 0;
    for (int i = 3; i < 30; i++) samp[i] = 100;
    for (int i = 30; i < 60; i++) samp[i] = 201;
    nsamp = 80;
    run(100, 50, "R2 strict threshold");
    // R3: equal maxima, earliest reported
    for (int i = 0; i < MAXS; i++) samp[i] = 0;
    samp[5] = 500; samp[6] = 200; samp[7] = 500; samp[9] = 499;
    nsamp = 40;
    run(300, 20, "R3 tie");
    // Sweep period, threshold, starting RR estimate
    for (int pi = 0; pi < 4; pi++)
      for (int ti = 0; ti < 4; ti++)
        for (int ri = 0; ri < 3; ri++) begin
          int p = periods[pi];
          int rrd = (ri == 0) ? p : (ri == 1) ? 3 * p : 12;
          build_beats(p, 7, 260);
          run(ths[ti], rrd, $sformatf("p%0d t%0d r%0d", p, ths[ti], rrd));
        end
    finish_run();
  end
endmodule